// File: doc/BRIEF.md
# Up-Counting Event Timer with Auto-Reload

This block is a general-purpose timer whose counter climbs by one on every functional tick while it is running and signals an event when it wraps from all-ones to zero. Software programs it through a narrow register port: a reload value, the live counter, a control word with run and reload bits, an interrupt enable, a write-one-to-clear status flag, a configuration bit choosing posted or non-posted writes, and a read-only word of pending-write bits. To obtain an event after a chosen interval, software loads the counter with all-ones minus that interval and sets the run bit. With reload clear the timer fires once and stops itself. With reload set it fires periodically. Started from zero with a zero reload value and reload set, it serves as a free-running time base whose count can be read at any time.

Writes to the three timer-side registers (reload value, counter, control) pass through a resynchronisation stage modelled as a fixed latency of `SYNC_CYCLES` clock edges. The stage is a three-state machine. `SY_IDLE` waits for a timer-side write and captures it (transition *capture*). `SY_WAIT` counts the resynchronisation cycles (transition *wait done* once the count reaches its last value). `SY_APPLY` drives the captured value into the timer and returns to `SY_IDLE` (transition *apply*). In posted mode the bus is released at capture and pending bits report the write in flight. In non-posted mode the bus is held until the apply cycle. A functional-tick input `tick` qualifies counting, so the timer can run slower than the register clock.

Top module: `tmr_upcount`

## Requirements
- R1: While the run bit is set, the counter increases by exactly one on every clock edge at which `tick` is high. It does not change when `tick` is low or when the run bit is clear, unless the counter is written.
- R2: Overflow happens on the tick that takes the counter from 0xFFFFFFFF to the next value. A counter loaded with 0xFFFFFFFF minus N reads 0xFFFFFFFF after N ticks, and the flag is set by the tick after that (tick N+1).
- R3: With the reload bit (control bit 1) set, an overflow loads the counter from the reload register (address 0) and counting continues. Overflows then repeat every N+1 ticks for a reload value of 0xFFFFFFFF minus N.
- R4: With the reload bit clear, an overflow clears the run bit (control bit 0) by hardware. The counter then stays at zero.
- R5: Writing the control register with the run bit clear stops the counter, and its value stays frozen.
- R6: Status bit 0 (address 4) is set by every overflow, whatever the enable is. Writing 1 to that bit clears it. Writing 0 leaves it unchanged. An overflow in the same cycle as a clear wins.
- R7: `irq` is a level equal to status bit 0 AND enable bit 0 (address 3). It stays high until the flag is cleared or the enable is cleared.
- R8: Posted mode is selected by configuration bit 0 (address 5) = 1. A timer-side write (address 0, 1 or 2) is accepted at the first edge at which `reg_wr_ready` is high. It takes effect exactly `SYNC_CYCLES` (3) edges later. Until then, the pending word (address 6) shows bit 0 for the reload value, bit 1 for the counter or bit 2 for control. A further timer-side write is held off until the earlier one has taken effect, so it is accepted 4 edges after the earlier one.
- R9: In non-posted mode (configuration bit 0 = 0) a timer-side write holds `reg_wr_ready` low until the value is applied. The write is accepted `SYNC_CYCLES`+1 edges after it is first presented, and it is visible at the edge of acceptance.
- R10: With a reload value of 0, reload set and run set, the counter is a free-running time base. After a counter write it reads the number of ticks elapsed since that write. It wraps from 0xFFFFFFFF to 0 and flags the wrap.
- R11: After reset, the reload, counter, control, enable, status, configuration and pending registers all read 0, and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register and timer clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Functional tick; the counter advances only on edges where it is high |
| reg_wr | input | 1 | Write request, held until `reg_wr_ready` |
| reg_addr | input | 3 | Register address for reads and writes |
| reg_wdata | input | 32 | Write data |
| reg_wr_ready | output | 1 | Write accepted at the edge where this and `reg_wr` are both high |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| irq | output | 1 | Overflow interrupt level |

## Verification
The acceptance edge of every write is recorded as a cycle number. From it the bench works out when the write takes effect: 3 edges after acceptance in posted mode, and at acceptance itself in non-posted mode. Counter values and the overflow flag are then predicted for particular cycles. The flag must still be low one edge before the predicted overflow edge (effective start plus N+1) and high right after it. The next periodic overflow is predicted N+1 edges later, and a status clear takes effect at its own acceptance edge. All samples are taken at the falling edge after the edge in question, so every register on the path has already updated.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic [2:0] {
        RA_LOAD  = 3'd0,
        RA_COUNT = 3'd1,
        RA_CTRL  = 3'd2,
        RA_IEN   = 3'd3,
        RA_ISTAT = 3'd4,
        RA_CFG   = 3'd5,
        RA_PEND  = 3'd6,
        RA_NONE  = 3'd7
    } reg_addr_e;

    typedef enum logic [1:0] {
        SY_IDLE  = 2'd0,
        SY_WAIT  = 2'd1,
        SY_APPLY = 2'd2
    } sync_state_e;

    // timer-side register count; one-hot select bit index equals its address
    localparam int NUM_TREG    = 3;
    localparam int SEL_LOAD    = 0;
    localparam int SEL_COUNT   = 1;
    localparam int SEL_CTRL    = 2;
    localparam int CTRL_RUN    = 0;
    localparam int CTRL_RELOAD = 1;

    typedef logic [NUM_TREG-1:0] treg_sel_t;

endpackage

// File: rtl/tmr_post_sync.sv
module tmr_post_sync
    import tmr_pkg::*;
#(
    parameter int DW          = 32,
    parameter int SYNC_CYCLES = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          posted,
    input  logic          wr_req,
    input  treg_sel_t     wr_sel,
    input  logic [DW-1:0] wr_data,
    output logic          wr_ready,
    output logic          apply_en,
    output treg_sel_t     apply_sel,
    output logic [DW-1:0] apply_data,
    output treg_sel_t     pend
);
    localparam int CW = (SYNC_CYCLES > 2) ? $clog2(SYNC_CYCLES) : 1;
    localparam logic [CW-1:0] WAIT_LAST = CW'(SYNC_CYCLES - 2);

    sync_state_e   state, state_nx;
    logic [CW-1:0] cnt;
    treg_sel_t     sel_q;
    logic [DW-1:0] data_q;

    // next-state selection
    always_comb begin
        state_nx = state;
        unique case (state)
            SY_IDLE:  if (wr_req)           state_nx = SY_WAIT;   // capture
            SY_WAIT:  if (cnt == WAIT_LAST) state_nx = SY_APPLY;  // wait done
            SY_APPLY:                       state_nx = SY_IDLE;   // apply
            default:                        state_nx = SY_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= SY_IDLE;
        else        state <= state_nx;
    end

    // captured write and wait counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt    <= '0;
            sel_q  <= '0;
            data_q <= '0;
        end else if (state == SY_IDLE && wr_req) begin
            cnt    <= '0;
            sel_q  <= wr_sel;
            data_q <= wr_data;
        end else if (state == SY_WAIT) begin
            cnt    <= cnt + 1'b1;
        end
    end

    // outputs
    always_comb begin
        wr_ready   = posted ? (state == SY_IDLE) : (state == SY_APPLY);
        apply_en   = (state == SY_APPLY);
        apply_sel  = sel_q;
        apply_data = data_q;
        pend       = (state != SY_IDLE) ? sel_q : '0;
    end

    AST_PEND_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pend));                                               // R8
    AST_ACCEPT_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SY_IDLE && wr_req && wr_sel != '0) |=> (pend != '0)); // R8
    AST_APPLY_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        apply_en |=> !apply_en);                                       // R8
    AST_WAIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SY_WAIT) |-> (cnt <= WAIT_LAST));                    // R8
    AST_NP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!posted && wr_ready) |=> (state == SY_IDLE));                 // R9

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
    import tmr_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          apply_en,
    input  treg_sel_t     apply_sel,
    input  logic [DW-1:0] apply_data,
    output logic [DW-1:0] count,
    output logic [DW-1:0] load,
    output logic          run,
    output logic          reload,
    output logic          ovf
);
    logic wr_load, wr_count, wr_ctrl;

    always_comb begin
        wr_load  = apply_en && apply_sel[SEL_LOAD];
        wr_count = apply_en && apply_sel[SEL_COUNT];
        wr_ctrl  = apply_en && apply_sel[SEL_CTRL];
        ovf      = run && tick && (count == '1) && !wr_count;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                count <= '0;
        else if (wr_count)         count <= apply_data;
        else if (run && tick)      count <= (count == '1 && reload) ? load : count + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       load <= '0;
        else if (wr_load) load <= apply_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run    <= 1'b0;
            reload <= 1'b0;
        end else if (wr_ctrl) begin
            run    <= apply_data[CTRL_RUN];
            reload <= apply_data[CTRL_RELOAD];
        end else if (ovf && !reload) begin
            run    <= 1'b0;
        end
    end

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick && count != '1 && !wr_count) |=> (count == $past(count) + 1'b1)); // R1
    AST_TICK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !wr_count) |=> $stable(count));                                    // R1
    AST_RELOAD_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && reload) |=> (count == $past(load)));                                 // R3
    AST_ONESHOT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !reload && !wr_ctrl) |=> (!run && count == '0));                     // R4
    AST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !wr_count) |=> $stable(count));                                     // R5

endmodule

// File: rtl/tmr_upcount.sv
module tmr_upcount
    import tmr_pkg::*;
#(
    parameter int DW          = 32,
    parameter int SYNC_CYCLES = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          reg_wr,
    input  logic [2:0]    reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic          reg_wr_ready,
    output logic [DW-1:0] reg_rdata,
    output logic          irq
);
    reg_addr_e     addr_e;
    treg_sel_t     wr_sel, apply_sel, pend;
    logic          is_treg, wr_req, sync_ready, apply_en;
    logic [DW-1:0] apply_data, count, load;
    logic          run, reload, ovf;
    logic          posted_q, ien_q, stat_q, stat_clr;

    assign addr_e = reg_addr_e'(reg_addr);

    // one-hot select: bit index equals register address
    for (genvar gi = 0; gi < NUM_TREG; gi++) begin : g_sel
        assign wr_sel[gi] = (reg_addr == 3'(gi));
    end

    assign is_treg      = (wr_sel != '0);
    assign wr_req       = reg_wr && is_treg;
    assign reg_wr_ready = is_treg ? sync_ready : 1'b1;
    assign stat_clr     = reg_wr && (addr_e == RA_ISTAT) && reg_wdata[0];

    tmr_post_sync #(.DW(DW), .SYNC_CYCLES(SYNC_CYCLES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .posted     (posted_q),
        .wr_req     (wr_req),
        .wr_sel     (wr_sel),
        .wr_data    (reg_wdata),
        .wr_ready   (sync_ready),
        .apply_en   (apply_en),
        .apply_sel  (apply_sel),
        .apply_data (apply_data),
        .pend       (pend)
    );

    tmr_counter #(.DW(DW)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .apply_en   (apply_en),
        .apply_sel  (apply_sel),
        .apply_data (apply_data),
        .count      (count),
        .load       (load),
        .run        (run),
        .reload     (reload),
        .ovf        (ovf)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            posted_q <= 1'b0;
            ien_q    <= 1'b0;
            stat_q   <= 1'b0;
        end else begin
            if (reg_wr && addr_e == RA_CFG) posted_q <= reg_wdata[0];
            if (reg_wr && addr_e == RA_IEN) ien_q    <= reg_wdata[0];
            stat_q <= ovf || (stat_q && !stat_clr);
        end
    end

    assign irq = stat_q && ien_q;

    always_comb begin
        reg_rdata = '0;
        unique case (addr_e)
            RA_LOAD:  reg_rdata = load;
            RA_COUNT: reg_rdata = count;
            RA_CTRL: begin
                reg_rdata[CTRL_RUN]    = run;
                reg_rdata[CTRL_RELOAD] = reload;
            end
            RA_IEN:   reg_rdata[0] = ien_q;
            RA_ISTAT: reg_rdata[0] = stat_q;
            RA_CFG:   reg_rdata[0] = posted_q;
            RA_PEND:  reg_rdata[NUM_TREG-1:0] = pend;
            RA_NONE:  reg_rdata = '0;
            default:  reg_rdata = '0;
        endcase
    end

    AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> stat_q);                                                   // R6
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q && !stat_clr) |=> stat_q);                                 // R6
    AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !stat_clr && !(reg_wr && addr_e == RA_IEN)) |=> irq);      // R7

endmodule

// File: tb/tmr_upcount_test.sv
`timescale 1ns/100ps
module tmr_upcount_test;
    localparam int SYNC = 3;
    localparam logic [2:0] A_LOAD = 3'd0, A_COUNT = 3'd1, A_CTRL = 3'd2, A_IEN = 3'd3,
                           A_ISTAT = 3'd4, A_CFG = 3'd5, A_PEND = 3'd6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b1;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = '0;
    logic        reg_wr_ready;
    logic [31:0] reg_rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int acc = 0;
    int wstart = 0;
    bit done = 1'b0;

    tmr_upcount #(.DW(32), .SYNC_CYCLES(SYNC)) uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_wr_ready(reg_wr_ready), .reg_rdata(reg_rdata), .irq(irq)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic int eff(input int a, input bit p);
        return p ? a + SYNC : a;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1; wstart = cyc;
        forever begin
            #0.5;
            if (reg_wr_ready) begin
                @(posedge clk);
                break;
            end
            @(posedge clk);
        end
        #0.5;
        reg_wr = 1'b0;
        acc = cyc;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a;
        #0.2;
        d = reg_rdata;
    endtask

    task automatic wait_cyc(input int c);
        if (cyc > c) chk("timing", 32'(cyc), 32'(c));
        while (cyc < c) begin
            @(posedge clk);
            #0.5;
        end
        @(negedge clk);
    endtask

    task automatic wr_t(input logic [2:0] a, input logic [31:0] d, input bit p);
        wr(a, d);
        wait_cyc(eff(acc, p));
    endtask

    task automatic oneshot(input int n, input bit p, input bit en);
        logic [31:0] v;
        int a0;
        wr(A_CFG, 32'(p));
        wr_t(A_CTRL, 32'd0, p);
        wr(A_ISTAT, 32'd1);
        wr(A_IEN, 32'(en));
        wr_t(A_COUNT, ~32'(n), p);
        wr(A_CTRL, 32'd1);
        a0 = eff(acc, p);
        wait_cyc(a0 + n);
        rd(A_COUNT, v); chk("R1 count reaches all-ones after N ticks", v, 32'hFFFF_FFFF);
        chk("R2 no event before tick N+1", 32'(irq), 32'd0);
        rd(A_ISTAT, v); chk("R2 flag low before tick N+1", v, 32'd0);
        wait_cyc(a0 + n + 1);
        chk("R7 irq follows flag and enable", 32'(irq), 32'(en));
        rd(A_ISTAT, v); chk("R6 flag set on overflow", v, 32'd1);
        rd(A_CTRL, v);  chk("R4 run cleared after one-shot", v, 32'd0);
        rd(A_COUNT, v); chk("R4 counter at zero after one-shot", v, 32'd0);
        wait_cyc(a0 + n + 4);
        rd(A_COUNT, v); chk("R4 counter holds after one-shot", v, 32'd0);
    endtask

    task automatic periodic(input int n, input bit p);
        logic [31:0] v;
        int a0;
        wr(A_CFG, 32'(p));
        wr_t(A_CTRL, 32'd0, p);
        wr(A_ISTAT, 32'd1);
        wr(A_IEN, 32'd1);
        wr_t(A_LOAD, ~32'(n), p);
        wr_t(A_COUNT, ~32'(n), p);
        wr(A_CTRL, 32'd3);
        a0 = eff(acc, p);
        wait_cyc(a0 + n);
        chk("R3 no event before first period", 32'(irq), 32'd0);
        wait_cyc(a0 + n + 1);
        chk("R3 first periodic event", 32'(irq), 32'd1);
        rd(A_COUNT, v); chk("R3 counter reloaded", v, ~32'(n));
        wr(A_ISTAT, 32'd1);
        wait_cyc(acc);
        chk("R6 write-one clears flag", 32'(irq), 32'd0);
        wait_cyc(a0 + 2 * n + 1);
        chk("R3 no event before second period", 32'(irq), 32'd0);
        wait_cyc(a0 + 2 * n + 2);
        chk("R3 second periodic event after N+1 ticks", 32'(irq), 32'd1);
        rd(A_COUNT, v); chk("R3 counter reloaded again", v, ~32'(n));
        rd(A_CTRL, v);  chk("R3 run and reload stay set", v, 32'd3);
        wr_t(A_CTRL, 32'd0, p);
        rd(A_COUNT, v);
        wait_cyc(cyc + 5);
        begin
            logic [31:0] v2;
            rd(A_COUNT, v2); chk("R5 stopped counter frozen", v2, v);
        end
    endtask

    initial begin
        logic [31:0] v;
        int a1, a2;
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R11 reset state
        rd(A_LOAD, v);  chk("R11 reload value after reset", v, 32'd0);
        rd(A_COUNT, v); chk("R11 counter after reset", v, 32'd0);
        rd(A_CTRL, v);  chk("R11 control after reset", v, 32'd0);
        rd(A_IEN, v);   chk("R11 enable after reset", v, 32'd0);
        rd(A_ISTAT, v); chk("R11 status after reset", v, 32'd0);
        rd(A_CFG, v);   chk("R11 configuration after reset", v, 32'd0);
        rd(A_PEND, v);  chk("R11 pending after reset", v, 32'd0);
        chk("R11 irq low after reset", 32'(irq), 32'd0);

        // R8 posted latency and pending bits
        wr(A_CFG, 32'd1);
        wr(A_COUNT, 32'h1234_5678);
        a1 = acc;
        wait_cyc(a1 + 1);
        rd(A_PEND, v);  chk("R8 counter write pending", v, 32'd2);
        rd(A_COUNT, v); chk("R8 old value one edge after accept", v, 32'd0);
        wait_cyc(a1 + 2);
        rd(A_COUNT, v); chk("R8 old value two edges after accept", v, 32'd0);
        wait_cyc(a1 + 3);
        rd(A_COUNT, v); chk("R8 new value three edges after accept", v, 32'h1234_5678);
        rd(A_PEND, v);  chk("R8 pending cleared", v, 32'd0);

        // R8 back-to-back writes stall
        wr(A_COUNT, 32'd7);
        a1 = acc;
        wr(A_LOAD, 32'd9);
        a2 = acc;
        chk("R8 second write held off", 32'(a2 - a1), 32'd4);
        wait_cyc(a2 + 1);
        rd(A_PEND, v); chk("R8 reload write pending", v, 32'd1);
        wait_cyc(a2 + 3);
        rd(A_LOAD, v); chk("R8 reload value applied", v, 32'd9);

        // R9 non-posted stall
        wr(A_CFG, 32'd0);
        wr(A_COUNT, 32'd5);
        chk("R9 non-posted accept delay", 32'(acc - wstart), 32'(SYNC + 1));
        wait_cyc(acc);
        rd(A_COUNT, v); chk("R9 value visible at accept", v, 32'd5);

        // directed one-shot corners
        oneshot(0, 1'b1, 1'b1);
        oneshot(1, 1'b0, 1'b1);
        oneshot(10, 1'b1, 1'b1);

        // R7/R6 enable gating
        oneshot(6, 1'b0, 1'b0);
        chk("R7 masked irq stays low", 32'(irq), 32'd0);
        wr(A_IEN, 32'd1); wait_cyc(acc);
        chk("R7 enabling raises pending irq", 32'(irq), 32'd1);
        wr(A_ISTAT, 32'd0); wait_cyc(acc);
        rd(A_ISTAT, v); chk("R6 write of zero ignored", v, 32'd1);
        wr(A_ISTAT, 32'd1); wait_cyc(acc);
        chk("R7 irq drops on clear", 32'(irq), 32'd0);

        // R1 tick gating
        wr(A_CFG, 32'd0);
        wr(A_LOAD, 32'd0);
        wr(A_COUNT, 32'd0);
        wr(A_CTRL, 32'd3);
        wait_cyc(acc + 4);
        tick = 1'b0;
        rd(A_COUNT, v);
        wait_cyc(cyc + 5);
        begin
            logic [31:0] v2;
            rd(A_COUNT, v2); chk("R1 no count without tick", v2, v);
        end
        tick = 1'b1;

        // R10 free-running base
        wr(A_COUNT, 32'd0);
        a1 = acc;
        wait_cyc(a1 + 100);
        rd(A_COUNT, v); chk("R10 elapsed ticks", v, 32'd100);
        wr(A_ISTAT, 32'd1);
        wr(A_COUNT, 32'hFFFF_FFF0);
        a1 = acc;
        wait_cyc(a1 + 20);
        rd(A_COUNT, v); chk("R10 wraps to zero", v, 32'd4);
        rd(A_ISTAT, v); chk("R10 wrap flagged", v, 32'd1);

        // constrained random mix
        for (int i = 0; i < 12; i++) begin
            int n;
            bit p;
            n = 4 + int'($urandom % 60);
            p = bit'($urandom % 2);
            if ($urandom % 2) periodic(n, p);
            else              oneshot(n, p, 1'b1);
        end
        periodic(4, 1'b1);
        periodic(5, 1'b0);

        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #600000;
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule